// File: doc/BRIEF.md
# Supervisor Reset Pulse Stretcher

This block produces the processor reset for a supervisor from two digital causes. The first is a supply-good flag, which is the result of comparing the supply against its threshold. The second is an active-low manual reset request, which arrives already synchronised and debounced. While either cause is present, the reset stays asserted. When the last cause goes away, the reset stays asserted for a fixed stretch interval and then releases. A cause that lasts only a single cycle still gives a full-length reset pulse.

The block drives two registered outputs: an active-low reset and its active-high complement. The stretch interval is given in milliseconds. It is turned into a count of clock cycles from a clock-frequency parameter, so one counter sets all the timing. After the block's own reset, the outputs start asserted and stay asserted until a first full interval has passed with no cause present. A watchdog timeout has no path into this block. Only the two causes listed above can assert the reset.

Top module: `supv_reset_gen`

## Requirements
- R1: While the block reset `rst_n` is low, `rst_out_n` is 0 and `rst_out` is 1.
- R2: After `rst_n` rises with `supply_ok`=1 and `mreq_n`=1, `rst_out_n` rises at the N-th clock edge after the first edge that samples `rst_n` high. N is CLK_HZ*STRETCH_MS/1000 cycles.
- R3: When `supply_ok` is sampled 0 at a clock edge, `rst_out_n` is 0 after that edge. It stays 0 for as long as `supply_ok` stays 0.
- R4: When `supply_ok` returns to 1 and `mreq_n` is 1, `rst_out_n` stays 0 through N-1 further edges. It rises at edge N, counting the first edge that samples the supply good as edge 0.
- R5: When `mreq_n` is sampled 0 at a clock edge, `rst_out_n` is 0 after that edge. It stays 0 for as long as `mreq_n` stays 0.
- R6: When `mreq_n` returns to 1 with the supply good, `rst_out_n` rises at edge N, counting the first edge that samples `mreq_n` high as edge 0.
- R7: A cause that is sampled at only one edge gives a low pulse on `rst_out_n` of N+1 cycles.
- R8: If a cause reappears while the stretch interval is running, the interval restarts. Release then comes N edges after the cause clears again.
- R9: While the two causes overlap, the reset stays asserted until both are gone. The interval is timed from the later of the two clears.
- R10: `rst_out` is the exact inverse of `rst_out_n` on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; its frequency is the CLK_HZ parameter |
| rst_n | input | 1 | Synchronous active-low block reset |
| supply_ok | input | 1 | 1 when the supply is above threshold |
| mreq_n | input | 1 | Active-low manual reset request, synchronised and debounced |
| rst_out_n | output | 1 | Active-low processor reset |
| rst_out | output | 1 | Active-high processor reset, inverse of rst_out_n |

## Verification
The assertions assume that `supply_ok` and `mreq_n` are clean, synchronous levels that change only between clock edges. They also assume the derived interval N is at least one cycle. The counter checks assume that a cause always reloads the count, so a running stretch can never be cut short. The bench changes both causes only on falling clock edges and sets CLK_HZ so that N is 50 cycles. It holds each cause for whole cycles, including single-cycle pulses and overlapping windows, so every input the design sees is a legal synchronous level.

// File: rtl/supv_pkg.sv
// Package: shared helpers for the supervisor reset generator.
// Assumes the clock frequency and interval give at least one cycle.
package supv_pkg;

    // Converts a millisecond interval into a count of clock cycles.
    function automatic int stretch_cycles(input int clk_hz, input int ms);
        longint prod;
        prod = longint'(clk_hz) * longint'(ms);
        return int'(prod / 1000);
    endfunction

    // Width of a down-counter that must hold the value n.
    function automatic int count_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/supv_cause_merge.sv
// Module: merges the supply-fault and manual-request causes into one
// active-high hold request. Assumes both inputs are synchronous levels.
module supv_cause_merge (
    input  logic supply_ok,
    input  logic mreq_n,
    output logic cause
);

    // Either an unhealthy supply or a pending manual request holds reset.
    always_comb begin
        cause = (~supply_ok) | (~mreq_n);
    end

endmodule

// File: rtl/supv_stretch_cnt.sv
// Module: stretch interval down-counter. It reloads to the full count
// whenever a cause is present and on block reset, and otherwise counts
// down to zero. busy is high while any of the interval is left.
module supv_stretch_cnt #(
    parameter int N = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cause,
    output logic busy
);
    localparam int CW = supv_pkg::count_width(N);
    localparam logic [CW-1:0] LOAD = CW'(N);

    logic [CW-1:0] cnt;

    // Reload on reset or cause; otherwise step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= LOAD;
        end else if (cause) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    // Remaining interval flag for the output stage.
    always_comb begin
        busy = (cnt != '0);
    end

    AST_RELOAD_ON_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> (cnt == LOAD)); // R8
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD); // R4
    AST_CNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause && busy) |=> (cnt == $past(cnt) - CW'(1))); // R6

endmodule

// File: rtl/supv_out_drv.sv
// Module: output stage. It registers the active-low reset and its
// active-high complement in two separate flops. Reset is held while a
// cause is present or the stretch counter is still busy.
module supv_out_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic cause,
    input  logic busy,
    output logic rst_out_n,
    output logic rst_out
);
    logic hold;

    // Reset request seen by the output flops.
    always_comb begin
        hold = cause | busy;
    end

    // Register both polarities; block reset forces the asserted state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_out_n <= 1'b0;
            rst_out   <= 1'b1;
        end else begin
            rst_out_n <= ~hold;
            rst_out   <= hold;
        end
    end

    AST_RESET_ASSERTS: assert property (@(posedge clk)
        !rst_n |=> (!rst_out_n && rst_out)); // R1
    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out != rst_out_n); // R10
    AST_RELEASE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> (!$past(cause) && !$past(busy))); // R7

endmodule

// File: rtl/supv_reset_gen.sv
// Module: top of the supervisor reset generator. It holds the processor
// reset during a supply fault or a manual request, and stretches it for
// STRETCH_MS milliseconds at CLK_HZ once the last cause is gone.
// Assumes supply_ok and mreq_n are synchronous, debounced levels.
module supv_reset_gen #(
    parameter int CLK_HZ     = 125_000_000,
    parameter int STRETCH_MS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic mreq_n,
    output logic rst_out_n,
    output logic rst_out
);
    localparam int N = supv_pkg::stretch_cycles(CLK_HZ, STRETCH_MS);

    logic cause;
    logic busy;

    supv_cause_merge i_merge (
        .supply_ok (supply_ok),
        .mreq_n    (mreq_n),
        .cause     (cause)
    );

    supv_stretch_cnt #(.N(N)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cause (cause),
        .busy  (busy)
    );

    supv_out_drv i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause     (cause),
        .busy      (busy),
        .rst_out_n (rst_out_n),
        .rst_out   (rst_out)
    );

    AST_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !rst_out_n); // R3
    AST_MANUAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !mreq_n |=> !rst_out_n); // R5

endmodule

// File: tb/test_supv_reset_gen.sv
// Scoreboard bench: driver tasks queue expected reset levels by cycle,
// a monitor on the falling edge pops and compares them.
module test_supv_reset_gen;
    localparam int CLK_HZ     = 250;
    localparam int STRETCH_MS = 200;
    localparam int N          = 50; // 250 Hz * 200 ms

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic mreq_n = 1'b1;
    logic rst_out_n;
    logic rst_out;
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int    at;
        logic  val;
        string tag;
    } exp_t;
    exp_t q[$];

    supv_reset_gen #(.CLK_HZ(CLK_HZ), .STRETCH_MS(STRETCH_MS)) i_supv_reset_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .mreq_n    (mreq_n),
        .rst_out_n (rst_out_n),
        .rst_out   (rst_out)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int at, input logic val, input string tag);
        exp_t e;
        e.at = at; e.val = val; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Monitor: the complement on every cycle, plus the queued expectations.
    always @(negedge clk) begin
        n_chk++;
        if (rst_out !== ~rst_out_n) begin
            n_fail++;
            $display("FAIL R10 cyc=%0d actual rst_out=%b expected=%b", cyc, rst_out, ~rst_out_n);
        end
        while (q.size() > 0 && q[0].at <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (e.at != cyc || rst_out_n !== e.val) begin
                n_fail++;
                $display("FAIL %s cyc=%0d actual rst_out_n=%b expected=%b", e.tag, cyc, rst_out_n, e.val);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        report();
        $finish;
    end

    // Driver: scenarios in sequence, each pushing its expectations first.
    initial begin
        int m;
        step(1);
        expect_at(cyc + 1, 1'b0, "R1");
        step(2);
        // R2: power-up release
        rst_n = 1'b1; m = cyc;
        expect_at(m + N, 1'b0, "R2");
        expect_at(m + N + 1, 1'b1, "R2");
        step(N + 5);

        // R3 then R4: supply fault held, then stretched
        supply_ok = 1'b0; m = cyc;
        expect_at(m + 1, 1'b0, "R3");
        expect_at(m + 10, 1'b0, "R3");
        expect_at(m + 19, 1'b0, "R3");
        step(20);
        supply_ok = 1'b1; m = cyc;
        expect_at(m + N, 1'b0, "R4");
        expect_at(m + N + 1, 1'b1, "R4");
        step(N + 5);

        // R5 then R6: manual request held, then stretched
        mreq_n = 1'b0; m = cyc;
        expect_at(m + 1, 1'b0, "R5");
        expect_at(m + 15, 1'b0, "R5");
        step(16);
        mreq_n = 1'b1; m = cyc;
        expect_at(m + N, 1'b0, "R6");
        expect_at(m + N + 1, 1'b1, "R6");
        step(N + 5);

        // R7: single-cycle supply glitch gives an N+1 cycle pulse
        supply_ok = 1'b0; m = cyc;
        step(1);
        supply_ok = 1'b1;
        expect_at(m + 1, 1'b0, "R7");
        expect_at(m + N + 1, 1'b0, "R7");
        expect_at(m + N + 2, 1'b1, "R7");
        step(N + 5);

        // R7: single-cycle manual request
        mreq_n = 1'b0; m = cyc;
        step(1);
        mreq_n = 1'b1;
        expect_at(m + 1, 1'b0, "R7");
        expect_at(m + N + 1, 1'b0, "R7");
        expect_at(m + N + 2, 1'b1, "R7");
        step(N + 5);

        // R8: cause reappears during the interval, which restarts
        supply_ok = 1'b0;
        step(5);
        supply_ok = 1'b1; m = cyc;
        step(20);
        mreq_n = 1'b0;
        step(1);
        mreq_n = 1'b1;
        expect_at(m + N + 1, 1'b0, "R8");
        expect_at(m + N + 21, 1'b0, "R8");
        expect_at(m + N + 22, 1'b1, "R8");
        step(N + 30);

        // R9: overlapping causes, timed from the later clear
        supply_ok = 1'b0; m = cyc;
        step(5);
        mreq_n = 1'b0;
        step(5);
        supply_ok = 1'b1;
        expect_at(m + N + 11, 1'b0, "R9");
        expect_at(m + N + 30, 1'b0, "R9");
        expect_at(m + N + 31, 1'b1, "R9");
        step(20);
        mreq_n = 1'b1;
        step(N + 10);

        n_chk++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R9 leftover expectations actual=%0d expected=0", q.size());
        end
        report();
        $finish;
    end

endmodule